// File: doc/BRIEF.md
# Interrupt pending/enable register unit

This unit holds the machine-level interrupt-pending and interrupt-enable words for one hart. A simple CSR access port carries an address, a two-bit operation code (write, set, clear) with write data, and a read strobe; read data comes back combinationally in the same cycle. Hardware lines for the machine external, timer and software interrupts, the supervisor external interrupt, a supervisor software-interrupt set strobe, a counter-overflow strobe and a small group of platform interrupts feed the pending word. The effective pending and enable vectors go straight to a trap arbiter.

Two supervisor views of the same state exist. A view shows a bit only if the matching bit of the delegation mask input is set. The supervisor external pending bit merges a software-owned flop with the external line. Reads return the OR of the two. Read-modify-write operations see and update only the software flop, so a forwarded external request is never latched into software state.

Top module: `irq_csr_unit`

## Requirements
- R1: After reset every pending flop and every enable flop is 0, so a read of the pending word shows only live input lines and a read of the enable word returns 0.
- R2: Address 0x344 selects the pending word, 0x304 the enable word, 0x144 the supervisor pending view and 0x104 the supervisor enable view. Op code 0 is none, 1 is write, 2 is set and 3 is clear. Read data is 0 when the read strobe is low or the address is unmapped, and an operation on an unmapped address changes no state.
- R3: On a writable bit, write loads the data bit, set ORs it in and clear removes it. The new value is visible from the next cycle.
- R4: Enable bits 1, 3, 5, 7, 9, 11, 13 and 16 upward (one per platform line) are writable. Every other enable bit reads 0.
- R5: Pending bits 3 (machine software), 7 (machine timer), 11 (machine external) and the platform bits from 16 upward mirror their input lines in the same cycle. Writes to them are ignored.
- R6: Pending bit 9 reads as the OR of a software flop and the supervisor external line. Write, set and clear compute the new flop value from the flop alone, and the line never enters it.
- R7: Pending bits 1 (supervisor software) and 5 (supervisor timer) are software-writable through the pending word. A set strobe on the supervisor software input forces bit 1 to 1 and wins over a clear issued in the same cycle.
- R8: Pending bit 13 (counter overflow) is software-writable, and the overflow strobe forces it to 1, winning over a concurrent clear.
- R9: A supervisor view read returns the machine value ANDed with the delegation mask and with the supervisor bit set {1, 5, 9, 13}.
- R10: Through the supervisor pending view only bits 1 and 13 can be written, and only where delegated. Through the supervisor enable view bits 1, 5, 9 and 13 can be written where delegated.
- R11: The pending output equals the pending-word read value and the enable output equals the enable flops, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | Operation: 0 none, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | XLEN | Write/set/clear data |
| csr_rd_i | input | 1 | Read strobe |
| csr_rdata_o | output | XLEN | Read data, same cycle |
| mei_i | input | 1 | Machine external interrupt line |
| mti_i | input | 1 | Machine timer interrupt line |
| msi_i | input | 1 | Machine software interrupt line |
| sei_i | input | 1 | Supervisor external line from the interrupt controller |
| ssip_set_i | input | 1 | Supervisor software pending set strobe |
| lcof_i | input | 1 | Counter-overflow set strobe |
| plat_irq_i | input | NPLAT | Platform interrupt lines, bits 16 upward |
| deleg_i | input | XLEN | Delegation mask for the supervisor views |
| pend_o | output | XLEN | Effective pending vector |
| en_o | output | XLEN | Enable vector |

## Verification
A wrong software flop shows at the next read of the pending word, on the pending output in the cycle after the access that corrupted it, and from then on until software rewrites it. The merged supervisor external bit can hide a lost or stuck software flop while the external line is high. The bench therefore drops the line after set and clear operations, so that the flop alone shows in the following read. A wrong delegation filter shows at once as a nonzero bit in a supervisor view read, or as an enable or pending bit that moves one cycle after a view write that should have left it alone.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam int BIT_SSI   = 1;
  localparam int BIT_MSI   = 3;
  localparam int BIT_STI   = 5;
  localparam int BIT_MTI   = 7;
  localparam int BIT_SEI   = 9;
  localparam int BIT_MEI   = 11;
  localparam int BIT_LCOF  = 13;
  localparam int PLAT_BASE = 16;

  localparam logic [11:0] ADDR_MIP = 12'h344;
  localparam logic [11:0] ADDR_MIE = 12'h304;
  localparam logic [11:0] ADDR_SIP = 12'h144;
  localparam logic [11:0] ADDR_SIE = 12'h104;

  // standard-cause masks (low 16 bits)
  localparam logic [15:0] STD_EN_WMASK   = 16'h2AAA;
  localparam logic [15:0] M_PEND_WMASK   = 16'h2222;
  localparam logic [15:0] S_VIEW_MASK    = 16'h2222;
  localparam logic [15:0] S_PEND_WMASK   = 16'h2002;

  function automatic logic apply_bit(csr_op_e op, logic old, logic wd);
    logic nv;
    case (op)
      OP_WRITE: nv = wd;
      OP_SET:   nv = old | wd;
      OP_CLEAR: nv = old & ~wd;
      default:  nv = old;
    endcase
    return nv;
  endfunction
endpackage

// File: rtl/irq_rmw_bit.sv
module irq_rmw_bit
  import irq_csr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  csr_op_e op_i,
  input  logic    wdata_i,
  input  logic    hw_set_i,
  output logic    q_o
);
  logic q_d;

  always_comb begin
    q_d = wr_en_i ? apply_bit(op_i, q_o, wdata_i) : q_o;
    q_d = q_d | hw_set_i; // hardware set wins over concurrent clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
  import irq_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NPLAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  csr_op_e          op_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [XLEN-1:0]  wmask_i,
  input  logic             mei_i,
  input  logic             mti_i,
  input  logic             msi_i,
  input  logic             sei_i,
  input  logic             ssip_set_i,
  input  logic             lcof_i,
  input  logic [NPLAT-1:0] plat_i,
  output logic [XLEN-1:0]  pend_o
);
  localparam int NSW = 4;
  localparam int SW_IDX [NSW] = '{BIT_SSI, BIT_STI, BIT_SEI, BIT_LCOF};

  logic [NSW-1:0] sw_q;

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    logic hw_set;
    if (SW_IDX[k] == BIT_SSI) begin : g_ssi
      assign hw_set = ssip_set_i;
    end else if (SW_IDX[k] == BIT_LCOF) begin : g_lcof
      assign hw_set = lcof_i;
    end else begin : g_none
      assign hw_set = 1'b0;
    end

    irq_rmw_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wmask_i[SW_IDX[k]]),
      .op_i     (op_i),
      .wdata_i  (wdata_i[SW_IDX[k]]),
      .hw_set_i (hw_set),
      .q_o      (sw_q[k])
    );
  end

  always_comb begin
    pend_o = '0;
    for (int k = 0; k < NSW; k++) pend_o[SW_IDX[k]] = sw_q[k];
    pend_o[BIT_SEI] = pend_o[BIT_SEI] | sei_i; // read-only OR, never fed back
    pend_o[BIT_MSI] = msi_i;
    pend_o[BIT_MTI] = mti_i;
    pend_o[BIT_MEI] = mei_i;
    pend_o[PLAT_BASE +: NPLAT] = plat_i;
  end

  logic unused_ok;
  assign unused_ok = ^{wdata_i, wmask_i};
endmodule

// File: rtl/irq_en_regs.sv
module irq_en_regs
  import irq_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NPLAT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] wmask_i,
  output logic [XLEN-1:0] en_o
);
  localparam logic [XLEN-1:0] EN_WMASK =
    XLEN'(STD_EN_WMASK) | (XLEN'((64'd1 << NPLAT) - 64'd1) << PLAT_BASE);

  for (genvar i = 0; i < XLEN; i++) begin : g_en
    if (EN_WMASK[i]) begin : g_rw
      irq_rmw_bit u_bit (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wmask_i[i]),
        .op_i     (op_i),
        .wdata_i  (wdata_i[i]),
        .hw_set_i (1'b0),
        .q_o      (en_o[i])
      );
    end else begin : g_ro
      assign en_o[i] = 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{wdata_i, wmask_i};
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0]     addr_i,
  input  logic            rd_i,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] en_i,
  input  logic [XLEN-1:0] deleg_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam logic [XLEN-1:0] S_VIEW = XLEN'(S_VIEW_MASK);

  logic [XLEN-1:0] s_filt;
  assign s_filt = deleg_i & S_VIEW;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADDR_MIP: rdata_o = pend_i;
        ADDR_MIE: rdata_o = en_i;
        ADDR_SIP: rdata_o = pend_i & s_filt;
        ADDR_SIE: rdata_o = en_i & s_filt;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
  import irq_csr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NPLAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      csr_addr_i,
  input  logic [1:0]       csr_op_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  input  logic             csr_rd_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic             mei_i,
  input  logic             mti_i,
  input  logic             msi_i,
  input  logic             sei_i,
  input  logic             ssip_set_i,
  input  logic             lcof_i,
  input  logic [NPLAT-1:0] plat_irq_i,
  input  logic [XLEN-1:0]  deleg_i,
  output logic [XLEN-1:0]  pend_o,
  output logic [XLEN-1:0]  en_o
);
  localparam logic [XLEN-1:0] M_PEND_W = XLEN'(M_PEND_WMASK);
  localparam logic [XLEN-1:0] S_PEND_W = XLEN'(S_PEND_WMASK);
  localparam logic [XLEN-1:0] S_EN_W   = XLEN'(S_VIEW_MASK);
  localparam logic [XLEN-1:0] M_EN_W   = '1; // filtered to writable bits inside irq_en_regs

  csr_op_e         op;
  logic            op_act;
  logic [XLEN-1:0] pend_wmask;
  logic [XLEN-1:0] en_wmask;

  assign op     = csr_op_e'(csr_op_i);
  assign op_act = (op != OP_NONE);

  always_comb begin
    pend_wmask = '0;
    en_wmask   = '0;
    if (op_act) begin
      case (csr_addr_i)
        ADDR_MIP: pend_wmask = M_PEND_W;
        ADDR_SIP: pend_wmask = deleg_i & S_PEND_W;
        ADDR_MIE: en_wmask   = M_EN_W;
        ADDR_SIE: en_wmask   = deleg_i & S_EN_W;
        default: ;
      endcase
    end
  end

  irq_pend_regs #(.XLEN(XLEN), .NPLAT(NPLAT)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .wdata_i    (csr_wdata_i),
    .wmask_i    (pend_wmask),
    .mei_i      (mei_i),
    .mti_i      (mti_i),
    .msi_i      (msi_i),
    .sei_i      (sei_i),
    .ssip_set_i (ssip_set_i),
    .lcof_i     (lcof_i),
    .plat_i     (plat_irq_i),
    .pend_o     (pend_o)
  );

  irq_en_regs #(.XLEN(XLEN), .NPLAT(NPLAT)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (csr_wdata_i),
    .wmask_i (en_wmask),
    .en_o    (en_o)
  );

  irq_read_mux #(.XLEN(XLEN)) u_rmux (
    .addr_i  (csr_addr_i),
    .rd_i    (csr_rd_i),
    .pend_i  (pend_o),
    .en_i    (en_o),
    .deleg_i (deleg_i),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/irq_csr_unit_chk.sv
module irq_csr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [11:0]     csr_addr_i,
  input logic [1:0]      csr_op_i,
  input logic            wdata_sei_i,
  input logic            csr_rd_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            sei_i,
  input logic            ssip_set_i,
  input logic            lcof_i,
  input logic [XLEN-1:0] deleg_i,
  input logic            pend_sei_i,
  input logic            pend_ssi_i,
  input logic            pend_lcof_i,
  input logic [XLEN-1:0] en_o
);
  logic sel_mip, sel_sip, sel_mie, sel_sie, mapped;
  assign sel_mip = (csr_addr_i == 12'h344);
  assign sel_mie = (csr_addr_i == 12'h304);
  assign sel_sip = (csr_addr_i == 12'h144);
  assign sel_sie = (csr_addr_i == 12'h104);
  assign mapped  = sel_mip | sel_mie | sel_sip | sel_sie;

  // R6
  seip_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_op_i == 2'd3 && sel_mip && wdata_sei_i) |=> (!pend_sei_i || sei_i));

  // R7
  ssip_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssip_set_i |=> pend_ssi_i);

  // R8
  lcof_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcof_i |=> pend_lcof_i);

  // R10
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_op_i != 2'd0 && (sel_mie || sel_sie)) |=> $stable(en_o));

  // R9
  sview_deleg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rd_i && (sel_sip || sel_sie)) |-> ((csr_rdata_o & ~deleg_i) == '0));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_rd_i || !mapped) |-> (csr_rdata_o == '0));
endmodule

bind irq_csr_unit irq_csr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_addr_i  (csr_addr_i),
  .csr_op_i    (csr_op_i),
  .wdata_sei_i (csr_wdata_i[9]),
  .csr_rd_i    (csr_rd_i),
  .csr_rdata_o (csr_rdata_o),
  .sei_i       (sei_i),
  .ssip_set_i  (ssip_set_i),
  .lcof_i      (lcof_i),
  .deleg_i     (deleg_i),
  .pend_sei_i  (pend_o[9]),
  .pend_ssi_i  (pend_o[1]),
  .pend_lcof_i (pend_o[13]),
  .en_o        (en_o)
);

// File: tb/irq_csr_unit_bench.sv
module irq_csr_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 32;
  localparam int NPLAT = 4;
  localparam logic [31:0] EN_W   = 32'h000F_2AAA;
  localparam logic [31:0] MP_W   = 32'h0000_2222;
  localparam logic [31:0] SV_M   = 32'h0000_2222;
  localparam logic [31:0] SP_W   = 32'h0000_2002;
  localparam logic [11:0] A_MIP = 12'h344, A_MIE = 12'h304, A_SIP = 12'h144, A_SIE = 12'h104;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic [1:0] op = '0;
  logic [31:0] wdata = '0;
  logic rd = 0;
  logic [31:0] rdata, pend, en;
  logic mei = 0, mti = 0, msi = 0, sei = 0, ssip_set = 0, lcof = 0;
  logic [NPLAT-1:0] plat = '0;
  logic [31:0] deleg = '0;

  logic [31:0] m_sw = '0;
  logic [31:0] m_en = '0;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_unit #(.XLEN(XLEN), .NPLAT(NPLAT)) u_irq_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_op_i(op),
    .csr_wdata_i(wdata), .csr_rd_i(rd), .csr_rdata_o(rdata),
    .mei_i(mei), .mti_i(mti), .msi_i(msi), .sei_i(sei),
    .ssip_set_i(ssip_set), .lcof_i(lcof), .plat_irq_i(plat),
    .deleg_i(deleg), .pend_o(pend), .en_o(en));

  function automatic logic [31:0] f_apply(logic [1:0] o, logic [31:0] old,
                                          logic [31:0] wd, logic [31:0] mask);
    logic [31:0] n;
    case (o)
      2'd1: n = wd;
      2'd2: n = old | wd;
      2'd3: n = old & ~wd;
      default: n = old;
    endcase
    return (n & mask) | (old & ~mask);
  endfunction

  function automatic logic [31:0] f_pend();
    logic [31:0] p;
    p = m_sw;
    p[9]  = p[9] | sei;
    p[3]  = msi;
    p[7]  = mti;
    p[11] = mei;
    p[16 +: NPLAT] = plat;
    return p;
  endfunction

  function automatic logic [31:0] f_read();
    if (!rd) return '0;
    case (addr)
      A_MIP: return f_pend();
      A_MIE: return m_en;
      A_SIP: return f_pend() & deleg & SV_M;
      A_SIE: return m_en & deleg & SV_M;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic [11:0] a, logic [1:0] o, logic [31:0] wd, logic r, string tag);
    logic [31:0] nsw, nen;
    @(negedge clk);
    addr = a; op = o; wdata = wd; rd = r;
    #1;
    chk(tag, "rdata", rdata, f_read());
    chk("R11", "pend_o", pend, f_pend());
    chk("R11", "en_o", en, m_en);
    nsw = m_sw; nen = m_en;
    if (o != 2'd0) begin
      case (a)
        A_MIP: nsw = f_apply(o, m_sw, wd, MP_W);
        A_SIP: nsw = f_apply(o, m_sw, wd, deleg & SP_W);
        A_MIE: nen = f_apply(o, m_en, wd, EN_W);
        A_SIE: nen = f_apply(o, m_en, wd, deleg & SV_M);
        default: ;
      endcase
    end
    nsw[1]  = nsw[1] | ssip_set;
    nsw[13] = nsw[13] | lcof;
    @(posedge clk);
    #1;
    m_sw = nsw; m_en = nen;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    step(A_MIP, 2'd0, '0, 1, "R1");
    step(A_MIE, 2'd0, '0, 1, "R1");

    // R4 writable enable bits
    step(A_MIE, 2'd1, 32'hFFFF_FFFF, 1, "R4");
    step(A_MIE, 2'd0, '0, 1, "R4");
    // R3 set/clear on enables
    step(A_MIE, 2'd3, 32'h0000_0A0A, 1, "R3");
    step(A_MIE, 2'd2, 32'h0000_0008, 1, "R3");
    step(A_MIE, 2'd0, '0, 1, "R3");

    // R5 read-only lines, writes ignored
    mti = 1; plat = 4'b1010;
    step(A_MIP, 2'd1, 32'hFFFF_FFFF, 1, "R5");
    step(A_MIP, 2'd0, '0, 1, "R5");
    mti = 0; plat = '0;
    step(A_MIP, 2'd0, '0, 1, "R5");

    // R6 merged supervisor external bit
    step(A_MIP, 2'd1, 32'h0, 1, "R6");
    sei = 1;
    step(A_MIP, 2'd2, 32'h0, 1, "R6");
    sei = 0;
    step(A_MIP, 2'd0, '0, 1, "R6");
    step(A_MIP, 2'd1, 32'h0000_0200, 1, "R6");
    sei = 1;
    step(A_MIP, 2'd3, 32'h0000_0200, 1, "R6");
    step(A_MIP, 2'd0, '0, 1, "R6");
    sei = 0;
    step(A_MIP, 2'd0, '0, 1, "R6");

    // R7 supervisor software: set strobe beats clear
    step(A_MIP, 2'd1, 32'h0000_0022, 1, "R7");
    ssip_set = 1;
    step(A_MIP, 2'd3, 32'h0000_0002, 1, "R7");
    ssip_set = 0;
    step(A_MIP, 2'd0, '0, 1, "R7");

    // R8 overflow strobe beats clear
    lcof = 1;
    step(A_MIP, 2'd3, 32'h0000_2000, 1, "R8");
    lcof = 0;
    step(A_MIP, 2'd0, '0, 1, "R8");
    step(A_MIP, 2'd3, 32'h0000_2000, 1, "R8");
    step(A_MIP, 2'd0, '0, 1, "R8");

    // R10 supervisor view writes
    deleg = 32'h0000_2222;
    step(A_SIP, 2'd1, 32'hFFFF_FFFF, 1, "R10");
    step(A_MIP, 2'd0, '0, 1, "R10");
    deleg = 32'h0000_0020;
    step(A_SIE, 2'd1, 32'h0, 1, "R10");
    step(A_MIE, 2'd0, '0, 1, "R10");

    // R9 supervisor view reads
    deleg = 32'h0000_0002;
    step(A_SIP, 2'd0, '0, 1, "R9");
    deleg = 32'hFFFF_FFFF;
    step(A_SIE, 2'd0, '0, 1, "R9");

    // R2 unmapped address and strobe low
    step(12'h345, 2'd1, 32'hFFFF_FFFF, 1, "R2");
    step(A_MIE, 2'd0, '0, 0, "R2");
    step(A_MIP, 2'd0, '0, 1, "R2");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      string tg;
      case ($urandom() % 5)
        0: begin a = A_MIP; tg = "R3"; end
        1: begin a = A_MIE; tg = "R4"; end
        2: begin a = A_SIP; tg = "R9"; end
        3: begin a = A_SIE; tg = "R10"; end
        default: begin a = 12'($urandom()); tg = "R2"; end
      endcase
      mei = 1'($urandom()); mti = 1'($urandom()); msi = 1'($urandom());
      sei = 1'($urandom());
      ssip_set = (($urandom() % 8) == 0);
      lcof     = (($urandom() % 8) == 0);
      plat  = NPLAT'($urandom());
      deleg = $urandom();
      step(a, 2'($urandom()), $urandom(), (($urandom() % 4) != 0), tg);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule